// File: doc/BRIEF.md
# Serial Flash Status Register and Write-Protect Gate

This block keeps the eight-bit status register of a 32 MB serial flash made of 512 blocks of 64 KB, and it rules on every write the command decoder hands it. A program or erase request carries a 25-bit byte address. Bits 24:16 of that address pick the 64 KB block, and the block is checked against the region that the four block-protect bits describe. A status-write request carries a new register image and is checked against the register-lock bit. Each request gets a one-cycle accept or reject pulse in the cycle after it is presented, and an accepted request starts a busy period whose length in cycles comes in on an input.

The register holds two volatile bits and six persistent bits. The volatile bits are bit 0, busy (write in progress), and bit 1, the write-enable latch. The persistent bits are bits 5:2, the block-protect code, then bit 6, quad enable, and bit 7, the register-lock bit. A reset reloads the persistent bits from a parameter and clears the volatile bits. When several requests arrive in one cycle, a program/erase request goes first, then a status write, then latch-set, then latch-clear.

Top module: `flash_status_guard`

## Requirements
- R1: After reset, status_o reads {NV_INIT, 0, 0} (persistent bits 7:2 from the parameter, latch bit 1 and busy bit 0 at zero) and all four result pulses are low.
- R2: While bit 0 is 0, a latch-set request sets status bit 1 and a latch-clear request clears it; the change is visible in the next cycle.
- R3: A program/erase request with bit 1 = 1, bit 0 = 0 and an unprotected target block gives pe_accept_o = 1 in the next cycle, with status bit 0 already 1 in that cycle.
- R4: A program/erase request made while bit 0 = 0, with bit 1 = 0 or a protected target block, gives pe_reject_o = 1 in the next cycle, leaves bit 0 at 0 and clears bit 1.
- R5: With bit 5 = 0, protect codes 1 to 6 in bits 4:2 protect every block except the top 1, 2, 4, 8, 16 or 32 blocks respectively.
- R6: With bit 5 = 1, protect codes 1 to 6 in bits 4:2 protect every block except the lowest 1, 2, 4, 8, 16 or 32 blocks respectively.
- R7: Protect code 0 in bits 4:2 protects no block and code 7 protects every block, whatever the value of bit 5.
- R8: After an accepted request, bit 0 stays 1 for exactly busy_len_i cycles (a length of 0 counts as 1) and then falls together with bit 1.
- R9: While bit 0 = 1, every program/erase and status-write request is rejected, and latch-set and latch-clear requests are ignored; the register keeps its value.
- R10: An accepted status write (bit 1 = 1, bit 0 = 0, bit 7 = 0) loads data bits 7:2 into status bits 7:2, ignores data bits 1:0, raises sr_accept_o and starts the same busy period.
- R11: With status bit 7 = 1, a status write is rejected with sr_reject_o, bits 7:2 keep their value and bit 1 is cleared.
- R12: Only address bits 24:16 select the block; the lower 16 bits have no effect on the protection decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wren_i | input | 1 | Set the write-enable latch |
| wrdi_i | input | 1 | Clear the write-enable latch |
| wrsr_i | input | 1 | Status-write request |
| wrsr_data_i | input | 8 | New status image |
| pe_i | input | 1 | Program or erase request |
| pe_addr_i | input | ADDR_W (25) | Byte address of the program or erase |
| busy_len_i | input | CNT_W (16) | Busy period in cycles |
| status_o | output | 8 | Status register |
| pe_accept_o | output | 1 | Program/erase accepted (pulse) |
| pe_reject_o | output | 1 | Program/erase rejected (pulse) |
| sr_accept_o | output | 1 | Status write accepted (pulse) |
| sr_reject_o | output | 1 | Status write rejected (pulse) |

## Verification
The protection decode is probed with address pairs that sit on either side of the edge of each region. The pairs cover the top-anchored codes 1 and 6, the bottom-anchored codes 1 and 6, and the all and none codes under both anchors. Some pairs differ only in the 16 low address bits, which separates block selection from byte offset. Requests are also issued with the latch clear, while busy, and with the register lock set. This tells a lost latch check, a missing busy interlock and a lock that does not hold apart from a faulty decode. Busy lengths of 3, 0 and 5 show whether the count is off by one and how a zero length is handled.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int unsigned SR_W = 8;
   localparam int unsigned BP_W = 4;
   localparam int unsigned NV_W = SR_W - 2;

   typedef struct packed {
      logic       lock;
      logic       quad;
      logic [3:0] bp;
      logic       wel;
      logic       wip;
   } fsr_status_t;

   typedef enum logic [1:0] {
      DEC_IDLE   = 2'd0,
      DEC_ACCEPT = 2'd1,
      DEC_REJECT = 2'd2
   } fsr_dec_e;
endpackage

// File: rtl/fsr_prot_decode.sv
module fsr_prot_decode
   import fsr_pkg::*;
#(
   parameter int unsigned BLK_W         = 9,
   parameter bit          BOTTOM_ON_SET = 1'b1
) (
   input  logic [BP_W-1:0]  bp_i,
   input  logic [BLK_W-1:0] blk_i,
   output logic             prot_o
);
   localparam int unsigned STEPS   = (1 << (BP_W - 1)) - 2;
   localparam int unsigned NUM_BLK = 1 << BLK_W;

   if (BLK_W < STEPS) begin : g_bad_width
      $error("fsr_prot_decode: BLK_W too small for the region sizes");
   end

   // per-step comparators: top-anchored keeps the upper 2^g blocks open,
   // bottom-anchored keeps the lower 2^g blocks open
   logic [STEPS-1:0] lower_hit;
   logic [STEPS-1:0] upper_hit;
   for (genvar g = 0; g < STEPS; g++) begin : g_step
      localparam logic [BLK_W-1:0] OPEN_CNT  = BLK_W'(1 << g);
      localparam logic [BLK_W-1:0] LOW_LIMIT = BLK_W'(NUM_BLK - (1 << g));
      assign lower_hit[g] = (blk_i <  LOW_LIMIT);
      assign upper_hit[g] = (blk_i >= OPEN_CNT);
   end

   logic anchor_bottom;
   if (BOTTOM_ON_SET) begin : g_anchor_set
      assign anchor_bottom = bp_i[BP_W-1];
   end else begin : g_anchor_clr
      assign anchor_bottom = ~bp_i[BP_W-1];
   end

   logic [BP_W-2:0] code;
   logic [BP_W-2:0] idx;
   assign code = bp_i[BP_W-2:0];
   assign idx  = code - 1'b1;

   always_comb begin
      if (code == '0) begin
         prot_o = 1'b0;
      end else if (code == '1) begin
         prot_o = 1'b1;
      end else begin
         prot_o = anchor_bottom ? upper_hit[idx] : lower_hit[idx];
      end
   end
endmodule

// File: rtl/fsr_busy_timer.sv
module fsr_busy_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             busy_o,
   output logic             last_o
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("fsr_busy_timer: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= (len_i == '0) ? CNT_W'(1) : len_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);
   assign last_o = (cnt_q == CNT_W'(1));

   // a new operation may only start from idle
   assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
   import fsr_pkg::*;
#(
   parameter int unsigned    ADDR_W    = 25,
   parameter int unsigned    BLK_SHIFT = 16,
   parameter int unsigned    CNT_W     = 16,
   parameter logic [NV_W-1:0] NV_INIT  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wren_i,
   input  logic              wrdi_i,
   input  logic              wrsr_i,
   input  logic [SR_W-1:0]   wrsr_data_i,
   input  logic              pe_i,
   input  logic [ADDR_W-1:0] pe_addr_i,
   input  logic [CNT_W-1:0]  busy_len_i,
   output logic [SR_W-1:0]   status_o,
   output logic              pe_accept_o,
   output logic              pe_reject_o,
   output logic              sr_accept_o,
   output logic              sr_reject_o
);
   localparam int unsigned BLK_W = ADDR_W - BLK_SHIFT;

   if (ADDR_W <= BLK_SHIFT) begin : g_bad_addr
      $error("flash_status_guard: ADDR_W must exceed BLK_SHIFT");
   end

   logic [NV_W-1:0] nv_q;
   logic            wel_q;
   logic            wip;
   logic            busy_last;
   logic            prot;
   logic            start;
   fsr_dec_e        pe_dec;
   fsr_dec_e        sr_dec;
   fsr_status_t     sr_view;
   fsr_status_t     wr_img;

   assign sr_view = fsr_status_t'({nv_q, wel_q, wip});
   assign wr_img  = fsr_status_t'(wrsr_data_i);
   assign status_o = sr_view;

   fsr_prot_decode #(
      .BLK_W        (BLK_W),
      .BOTTOM_ON_SET(1'b1)
   ) i_decode (
      .bp_i  (sr_view.bp),
      .blk_i (pe_addr_i[ADDR_W-1:BLK_SHIFT]),
      .prot_o(prot)
   );

   fsr_busy_timer #(
      .CNT_W(CNT_W)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .len_i  (busy_len_i),
      .busy_o (wip),
      .last_o (busy_last)
   );

   // request rulings; program/erase outranks status write
   always_comb begin
      pe_dec = DEC_IDLE;
      sr_dec = DEC_IDLE;
      if (pe_i) begin
         pe_dec = (wel_q && !wip && !prot) ? DEC_ACCEPT : DEC_REJECT;
      end else if (wrsr_i) begin
         sr_dec = (wel_q && !wip && !sr_view.lock) ? DEC_ACCEPT : DEC_REJECT;
      end
   end

   assign start = (pe_dec == DEC_ACCEPT) || (sr_dec == DEC_ACCEPT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_q        <= NV_INIT;
         wel_q       <= 1'b0;
         pe_accept_o <= 1'b0;
         pe_reject_o <= 1'b0;
         sr_accept_o <= 1'b0;
         sr_reject_o <= 1'b0;
      end else begin
         pe_accept_o <= (pe_dec == DEC_ACCEPT);
         pe_reject_o <= (pe_dec == DEC_REJECT);
         sr_accept_o <= (sr_dec == DEC_ACCEPT);
         sr_reject_o <= (sr_dec == DEC_REJECT);
         if (wip) begin
            if (busy_last) wel_q <= 1'b0;
         end else if (pe_dec == DEC_REJECT || sr_dec == DEC_REJECT) begin
            wel_q <= 1'b0;
         end else if (!start) begin
            if (wren_i)      wel_q <= 1'b1;
            else if (wrdi_i) wel_q <= 1'b0;
         end
         if (sr_dec == DEC_ACCEPT) begin
            nv_q <= {wr_img.lock, wr_img.quad, wr_img.bp};
         end
      end
   end

   assert_accept_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pe_accept_o |-> $past(status_o[1]) && !$past(status_o[0]));
   assert_accept_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pe_accept_o |-> status_o[0]);
   assert_reject_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_reject_o && !$past(status_o[0])) |-> (!status_o[0] && !status_o[1]));
   assert_open_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_i && wel_q && !wip && nv_q[2:0] == 3'b000) |=> pe_accept_o);
   assert_closed_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_i && nv_q[2:0] == 3'b111) |=> pe_reject_o);
   assert_lock_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sr_accept_o |-> !$past(status_o[7]));
   assert_finish_clears_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[0]) |-> !status_o[1]);
   assert_one_ruling_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({pe_accept_o, pe_reject_o, sr_accept_o, sr_reject_o}) <= 1);
endmodule

// File: tb/test_flash_status_guard.sv
`timescale 1ns/1ps
module test_flash_status_guard;
   localparam int K_IDLE = 0, K_WREN = 1, K_WRDI = 2, K_PE = 3, K_WRSR = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wren_i = 0, wrdi_i = 0, wrsr_i = 0, pe_i = 0;
   logic [7:0]  wrsr_data_i = '0;
   logic [24:0] pe_addr_i = '0;
   logic [15:0] busy_len_i = 16'd3;
   logic [7:0]  status_o;
   logic        pe_accept_o, pe_reject_o, sr_accept_o, sr_reject_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // bench model state
   logic [5:0] m_nv = '0;
   logic       m_wel = 0, m_wip = 0;
   int         m_left = 0;

   logic [11:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   flash_status_guard i_flash_status_guard (
      .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i),
      .wrsr_i(wrsr_i), .wrsr_data_i(wrsr_data_i), .pe_i(pe_i),
      .pe_addr_i(pe_addr_i), .busy_len_i(busy_len_i), .status_o(status_o),
      .pe_accept_o(pe_accept_o), .pe_reject_o(pe_reject_o),
      .sr_accept_o(sr_accept_o), .sr_reject_o(sr_reject_o));

   function automatic bit m_prot(logic [3:0] bp, int blk);
      int open_cnt;
      case (bp[2:0])
         3'd0: return 1'b0;
         3'd7: return 1'b1;
         3'd1: open_cnt = 1;
         3'd2: open_cnt = 2;
         3'd3: open_cnt = 4;
         3'd4: open_cnt = 8;
         3'd5: open_cnt = 16;
         default: open_cnt = 32;
      endcase
      if (bp[3]) return blk >= open_cnt;
      return blk <= 511 - open_cnt;
   endfunction

   task automatic step(int kind, logic [24:0] addr, logic [7:0] data, string tag);
      bit pa = 0, pr = 0, sa = 0, sr = 0;
      int n;
      @(negedge clk);
      wren_i = (kind == K_WREN); wrdi_i = (kind == K_WRDI);
      pe_i = (kind == K_PE); wrsr_i = (kind == K_WRSR);
      pe_addr_i = addr; wrsr_data_i = data;
      n = (busy_len_i == 0) ? 1 : int'(busy_len_i);
      if (m_wip) begin
         if (kind == K_PE) pr = 1;
         if (kind == K_WRSR) sr = 1;
         if (m_left == 1) begin m_wip = 0; m_wel = 0; m_left = 0; end
         else m_left--;
      end else begin
         case (kind)
            K_WREN: m_wel = 1;
            K_WRDI: m_wel = 0;
            K_PE: if (m_wel && !m_prot(m_nv[3:0], int'(addr[24:16]))) begin
                     pa = 1; m_wip = 1; m_left = n;
                  end else begin pr = 1; m_wel = 0; end
            K_WRSR: if (m_wel && !m_nv[5]) begin
                     sa = 1; m_nv = data[7:2]; m_wip = 1; m_left = n;
                  end else begin sr = 1; m_wel = 0; end
            default: ;
         endcase
      end
      exp_q.push_back({m_nv, m_wel, m_wip, pa, pr, sa, sr});
      tag_q.push_back(tag);
   endtask

   task automatic drain(string tag);
      while (m_wip) step(K_IDLE, '0, '0, tag);
   endtask

   task automatic set_sr(logic [7:0] v);
      step(K_WREN, '0, '0, "R2");
      step(K_WRSR, '0, v, "R10");
      drain("R8");
   endtask

   task automatic pe_try(logic [24:0] addr, string tag);
      step(K_WREN, '0, '0, "R2");
      step(K_PE, addr, '0, tag);
      drain("R8");
   endtask

   // monitor: compares one expected item per clock after outputs settle
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [11:0] e, a;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = {status_o, pe_accept_o, pe_reject_o, sr_accept_o, sr_reject_o};
         checks++;
         if (a !== e) begin
            fails++;
            $display("FAIL %s: got %h expected %h", t, a, e);
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      wren_i = 0; wrdi_i = 0; wrsr_i = 0; pe_i = 0;
      m_nv = '0; m_wel = 0; m_wip = 0; m_left = 0;
      repeat (2) @(negedge clk);
      checks++;
      if ({status_o, pe_accept_o, pe_reject_o, sr_accept_o, sr_reject_o} !== 12'h000) begin
         fails++;
         $display("FAIL R1: got %h expected %h",
                  {status_o, pe_accept_o, pe_reject_o, sr_accept_o, sr_reject_o}, 12'h000);
      end
      rst_n = 1;
   endtask

   initial begin
      do_reset();
      step(K_IDLE, '0, '0, "R1");
      // R2 latch set / clear
      step(K_WREN, '0, '0, "R2");
      step(K_WRDI, '0, '0, "R2");
      // R4 request without latch
      step(K_PE, 25'h0000000, '0, "R4");
      // R3 accept, R8 busy length 3
      pe_try(25'h0000000, "R3");
      // R10: code 1 top-anchored, low data bits ignored
      set_sr(8'b0000_0111);
      // R5 / R12 edges of code 1
      pe_try(25'h1FF0000, "R5");
      pe_try(25'h1FEFFFF, "R12");
      pe_try(25'h0000000, "R5");
      // R5 code 6: blocks 0..479 protected
      set_sr(8'b0001_1000);
      pe_try(25'h1DF0000, "R5");
      pe_try(25'h1E00000, "R5");
      // R6 code 1001: block 0 open, block 1 protected
      set_sr(8'b0010_0100);
      pe_try(25'h000FFFF, "R6");
      pe_try(25'h0010000, "R12");
      // R6 code 1110: lowest 32 open
      set_sr(8'b0011_1000);
      pe_try(25'h01F0000, "R6");
      pe_try(25'h0200000, "R6");
      pe_try(25'h1FFFFFF, "R6");
      // R7 codes 0111, 1111, 1000
      set_sr(8'b0001_1100);
      pe_try(25'h1FF0000, "R7");
      set_sr(8'b0011_1100);
      pe_try(25'h0000000, "R7");
      set_sr(8'b0010_0000);
      pe_try(25'h12C0000, "R7");
      pe_try(25'h1FFFFFF, "R7");
      // R9 requests during busy
      step(K_WREN, '0, '0, "R2");
      step(K_PE, 25'h0100000, '0, "R3");
      step(K_PE, 25'h0100000, '0, "R9");
      step(K_WRSR, '0, 8'hFF, "R9");
      step(K_WRDI, '0, '0, "R9");
      drain("R8");
      step(K_WRDI, '0, '0, "R9");
      // R8 zero and longer lengths
      busy_len_i = 16'd0;
      pe_try(25'h0300000, "R8");
      busy_len_i = 16'd5;
      pe_try(25'h0400000, "R8");
      // R10 quad bit, R11 lock
      set_sr(8'b0100_0000);
      set_sr(8'b1000_0011);
      step(K_WREN, '0, '0, "R2");
      step(K_WRSR, '0, 8'h00, "R11");
      step(K_IDLE, '0, '0, "R11");
      pe_try(25'h0500000, "R3");
      // R1 reset restores initial image
      do_reset();
      step(K_IDLE, '0, '0, "R1");
      repeat (3) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule